// File: doc/BRIEF.md
# Saturating ALU with Sticky Overflow

This block is a 16-bit arithmetic and logic unit. It adds, subtracts, passes either operand through, and performs bitwise logic on two operands. The answer goes to one of two destination registers. The result register is the normal output. The feedback register holds a value that a following operation can take back as an operand. Four status flags (zero, negative, carry, overflow) describe each operation. The operation, the destination and the operands are presented together with a one-cycle strobe. The selected register and the flags change on the next clock edge.

Two mode inputs change how overflow is handled. In saturation mode, an overflowing answer bound for the result register is clamped to the nearest representable extreme. The feedback register always receives the wrapped two's-complement value. In both cases the zero and negative flags describe the clamped value. In hold mode the overflow flag becomes sticky: once set, it stays set until a zero is written to it through a dedicated bus write port. That port can also set the flag, and it wins over an ALU update in the same cycle.

Top module: `sat_alu`

## Requirements
- R1: After reset, both destination registers read 0x0000 and all four flags read 0.
- R2: The operation is selected by `op_code`: 0 = x+y, 1 = x−y, 2 = pass y, 3 = x AND y, 4 = x OR y, 5 = x XOR y, 6 = pass x, 7 = NOT x. The answer appears at the selected register on the clock edge that samples `op_valid` high.
- R3: `dst_sel` = 0 writes the result register and `dst_sel` = 1 writes the feedback register. The register that is not selected keeps its value.
- R4: When `mode_sat_en` is 1 and `dst_sel` is 0, an add or subtract with signed overflow stores 0x7FFF if the exact result is positive and 0x8000 if it is negative.
- R5: When `dst_sel` is 1, the feedback register stores the wrapped 16-bit two's-complement answer, whatever the value of `mode_sat_en`.
- R6: The zero and negative flags describe the clamped value when `mode_sat_en` is 1, for either destination. They describe the wrapped value when `mode_sat_en` is 0.
- R7: The carry flag is the unsigned carry out for an add. For a subtract it is 1 when x ≥ y as unsigned numbers (no borrow). For pass and logic operations it is 0. The overflow outcome of pass and logic operations is 0.
- R8: With `mode_ovf_hold` at 0, every strobed operation sets the overflow flag to that operation's own signed overflow.
- R9: With `mode_ovf_hold` at 1, an overflow flag that is already 1 stays 1 through later operations, whether or not they overflow. A new overflow sets it.
- R10: `bus_ovf_we` high loads `bus_ovf_data` into the overflow flag on the next edge. This takes priority over any ALU update in the same cycle, and it is the only way to clear the flag in hold mode.
- R11: Without `op_valid`, both registers and the zero, negative and carry flags hold. Without `op_valid` and without `bus_ovf_we`, the overflow flag also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation select (see R2) |
| dst_sel | input | 1 | 0 = result register, 1 = feedback register |
| opnd_x | input | 16 | First operand |
| opnd_y | input | 16 | Second operand |
| mode_sat_en | input | 1 | Saturation mode enable |
| mode_ovf_hold | input | 1 | Sticky-overflow mode enable |
| bus_ovf_we | input | 1 | Direct write strobe for the overflow flag |
| bus_ovf_data | input | 1 | Value written to the overflow flag |
| res_q | output | 16 | Result register |
| fbk_q | output | 16 | Feedback register |
| flag_zero | output | 1 | Zero flag |
| flag_neg | output | 1 | Negative flag |
| flag_carry | output | 1 | Carry flag |
| flag_ovf | output | 1 | Overflow flag |

## Verification
The hardest situation to bring about is the one where the stored value and the flags describe different numbers. This happens on a saturating overflow into the feedback register. The stimulus adds 0x8000 to 0x8000 with saturation on, so the register wraps to 0x0000 while the zero flag must stay 0 and the negative flag must be 1. The same add is then repeated with saturation off, where the zero flag must become 1. A second hard case is a bus clear that collides with an overflowing operation in hold mode. The bench first makes the flag sticky, then issues both in one cycle and checks that the clear wins.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;
  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_PASSY = 3'd2,
    OP_AND   = 3'd3,
    OP_OR    = 3'd4,
    OP_XOR   = 3'd5,
    OP_PASSX = 3'd6,
    OP_NOTX  = 3'd7
  } alu_op_e;

  localparam logic DST_RES = 1'b0;
  localparam logic DST_FBK = 1'b1;
endpackage

// File: rtl/sat_alu_core.sv
module sat_alu_core
  import sat_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   y_i,
  output logic [W-1:0]   wrap_o,
  output logic           carry_o,
  output logic           ovf_o,
  output logic           true_neg_o
);
  localparam int EW = W + 1;

  function automatic logic [EW-1:0] sext(input logic [W-1:0] v);
    return {v[W-1], v};
  endfunction

  function automatic logic [EW-1:0] zext(input logic [W-1:0] v);
    return {1'b0, v};
  endfunction

  // exact signed sum in W+1 bits: top bit is the true sign
  function automatic logic [EW-1:0] exact_add(input logic [W-1:0] a, input logic [W-1:0] b);
    return sext(a) + sext(b);
  endfunction

  function automatic logic [EW-1:0] exact_sub(input logic [W-1:0] a, input logic [W-1:0] b);
    return sext(a) - sext(b);
  endfunction

  // unsigned carry out; for subtract it is the no-borrow indication
  function automatic logic carry_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [EW-1:0] u;
    u = zext(a) + zext(b);
    return u[W];
  endfunction

  function automatic logic carry_sub(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [EW-1:0] u;
    u = zext(a) + zext(~b) + EW'(1);
    return u[W];
  endfunction

  logic [EW-1:0] exact_s;

  always_comb begin
    exact_s    = '0;
    wrap_o     = '0;
    carry_o    = 1'b0;
    ovf_o      = 1'b0;
    true_neg_o = 1'b0;
    unique case (op_i)
      OP_ADD: begin
        exact_s    = exact_add(x_i, y_i);
        wrap_o     = exact_s[W-1:0];
        carry_o    = carry_add(x_i, y_i);
        ovf_o      = exact_s[W] ^ exact_s[W-1];
        true_neg_o = exact_s[W];
      end
      OP_SUB: begin
        exact_s    = exact_sub(x_i, y_i);
        wrap_o     = exact_s[W-1:0];
        carry_o    = carry_sub(x_i, y_i);
        ovf_o      = exact_s[W] ^ exact_s[W-1];
        true_neg_o = exact_s[W];
      end
      OP_PASSY: wrap_o = y_i;
      OP_AND:   wrap_o = x_i & y_i;
      OP_OR:    wrap_o = x_i | y_i;
      OP_XOR:   wrap_o = x_i ^ y_i;
      OP_PASSX: wrap_o = x_i;
      OP_NOTX:  wrap_o = ~x_i;
      default:  wrap_o = '0;
    endcase
    if (op_i != OP_ADD && op_i != OP_SUB) begin
      true_neg_o = wrap_o[W-1];
    end
  end
endmodule

// File: rtl/sat_alu_clamp.sv
module sat_alu_clamp #(
  parameter int W = 16
) (
  input  logic [W-1:0] wrap_i,
  input  logic         ovf_i,
  input  logic         true_neg_i,
  input  logic         sat_en_i,
  output logic [W-1:0] clamp_o,
  output logic         sat_hit_o
);
  localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

  assign sat_hit_o = sat_en_i & ovf_i;
  assign clamp_o   = sat_hit_o ? (true_neg_i ? NEG_LIMIT : POS_LIMIT) : wrap_i;
endmodule

// File: rtl/sat_alu_status.sv
module sat_alu_status #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_i,
  input  logic [W-1:0] val_i,
  input  logic         carry_i,
  input  logic         ovf_i,
  input  logic         hold_i,
  input  logic         bus_we_i,
  input  logic         bus_d_i,
  output logic         zero_o,
  output logic         neg_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic ovf_alu_next;

  assign ovf_alu_next = ovf_i | (hold_i & ovf_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_o  <= 1'b0;
      neg_o   <= 1'b0;
      carry_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      if (upd_i) begin
        zero_o  <= ~|val_i;
        neg_o   <= val_i[W-1];
        carry_o <= carry_i;
      end
      if (bus_we_i) begin
        ovf_o <= bus_d_i;
      end else if (upd_i) begin
        ovf_o <= ovf_alu_next;
      end
    end
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [OPC_W-1:0] op_code,
  input  logic             dst_sel,
  input  logic [W-1:0]     opnd_x,
  input  logic [W-1:0]     opnd_y,
  input  logic             mode_sat_en,
  input  logic             mode_ovf_hold,
  input  logic             bus_ovf_we,
  input  logic             bus_ovf_data,
  output logic [W-1:0]     res_q,
  output logic [W-1:0]     fbk_q,
  output logic             flag_zero,
  output logic             flag_neg,
  output logic             flag_carry,
  output logic             flag_ovf
);
  // named internal events, used by the bound checker
  logic [W-1:0] alu_wrap;
  logic         alu_carry;
  logic         alu_ovf;
  logic         alu_true_neg;
  logic [W-1:0] sat_val;
  logic         sat_hit;
  logic         res_we;
  logic         fbk_we;

  sat_alu_core #(.W(W)) u_core (
    .op_i       (alu_op_e'(op_code)),
    .x_i        (opnd_x),
    .y_i        (opnd_y),
    .wrap_o     (alu_wrap),
    .carry_o    (alu_carry),
    .ovf_o      (alu_ovf),
    .true_neg_o (alu_true_neg)
  );

  sat_alu_clamp #(.W(W)) u_clamp (
    .wrap_i     (alu_wrap),
    .ovf_i      (alu_ovf),
    .true_neg_i (alu_true_neg),
    .sat_en_i   (mode_sat_en),
    .clamp_o    (sat_val),
    .sat_hit_o  (sat_hit)
  );

  assign res_we = op_valid & (dst_sel == DST_RES);
  assign fbk_we = op_valid & (dst_sel == DST_FBK);

  // result register takes the clamped value, feedback register always wraps
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      fbk_q <= '0;
    end else begin
      if (res_we) res_q <= sat_val;
      if (fbk_we) fbk_q <= alu_wrap;
    end
  end

  // flags always see the clamped value, whichever register is written
  sat_alu_status #(.W(W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_i    (op_valid),
    .val_i    (sat_val),
    .carry_i  (alu_carry),
    .ovf_i    (alu_ovf),
    .hold_i   (mode_ovf_hold),
    .bus_we_i (bus_ovf_we),
    .bus_d_i  (bus_ovf_data),
    .zero_o   (flag_zero),
    .neg_o    (flag_neg),
    .carry_o  (flag_carry),
    .ovf_o    (flag_ovf)
  );
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk
  import sat_alu_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic         dst_sel,
  input logic         mode_ovf_hold,
  input logic         bus_ovf_we,
  input logic         bus_ovf_data,
  input logic [W-1:0] res_q,
  input logic [W-1:0] fbk_q,
  input logic         flag_zero,
  input logic         flag_neg,
  input logic         flag_carry,
  input logic         flag_ovf,
  input logic         alu_ovf,
  input logic         sat_hit
);
  localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

  a_r11_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(res_q) && $stable(fbk_q) && $stable(flag_zero)
                  && $stable(flag_neg) && $stable(flag_carry));

  a_r11_hold_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !bus_ovf_we) |=> $stable(flag_ovf));

  a_r3_res_only: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && dst_sel == DST_RES) |=> $stable(fbk_q));

  a_r3_fbk_only: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && dst_sel == DST_FBK) |=> $stable(res_q));

  a_r4_clamp_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && dst_sel == DST_RES && sat_hit) |=> (res_q == POS_LIMIT || res_q == NEG_LIMIT));

  a_r6_sat_not_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && sat_hit) |=> !flag_zero);

  a_r8_follow_op: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !mode_ovf_hold && !bus_ovf_we) |=> flag_ovf == $past(alu_ovf));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ovf && mode_ovf_hold && !bus_ovf_we) |=> flag_ovf);

  a_r10_bus_wins: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ovf_we |=> flag_ovf == $past(bus_ovf_data));
endmodule

bind sat_alu sat_alu_chk #(.W(W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .op_valid      (op_valid),
  .dst_sel       (dst_sel),
  .mode_ovf_hold (mode_ovf_hold),
  .bus_ovf_we    (bus_ovf_we),
  .bus_ovf_data  (bus_ovf_data),
  .res_q         (res_q),
  .fbk_q         (fbk_q),
  .flag_zero     (flag_zero),
  .flag_neg      (flag_neg),
  .flag_carry    (flag_carry),
  .flag_ovf      (flag_ovf),
  .alu_ovf       (alu_ovf),
  .sat_hit       (sat_hit)
);

// File: tb/sat_alu_tb.sv
`timescale 1ns/1ps
module sat_alu_tb;
  localparam int CLK_NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic        dst_sel = 1'b0;
  logic [15:0] opnd_x = '0;
  logic [15:0] opnd_y = '0;
  logic        mode_sat_en = 1'b0;
  logic        mode_ovf_hold = 1'b0;
  logic        bus_ovf_we = 1'b0;
  logic        bus_ovf_data = 1'b0;
  logic [15:0] res_q, fbk_q;
  logic        flag_zero, flag_neg, flag_carry, flag_ovf;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model state
  logic [15:0] e_res = '0, e_fbk = '0;
  logic        e_z = 0, e_n = 0, e_c = 0, e_v = 0;

  always #(CLK_NS/2) clk = ~clk;

  sat_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .dst_sel(dst_sel), .opnd_x(opnd_x), .opnd_y(opnd_y),
    .mode_sat_en(mode_sat_en), .mode_ovf_hold(mode_ovf_hold),
    .bus_ovf_we(bus_ovf_we), .bus_ovf_data(bus_ovf_data),
    .res_q(res_q), .fbk_q(fbk_q), .flag_zero(flag_zero), .flag_neg(flag_neg),
    .flag_carry(flag_carry), .flag_ovf(flag_ovf)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "res_q", res_q, e_res);
    chk(tag, "fbk_q", fbk_q, e_fbk);
    chk(tag, "zero", 16'(flag_zero), 16'(e_z));
    chk(tag, "neg", 16'(flag_neg), 16'(e_n));
    chk(tag, "carry", 16'(flag_carry), 16'(e_c));
    chk(tag, "ovf", 16'(flag_ovf), 16'(e_v));
  endtask

  // drive one cycle, advance the model from the requirements, compare after the edge
  task automatic apply(input string tag, input bit v, input int op, input bit dst,
                       input logic [15:0] x, input logic [15:0] y,
                       input bit sat, input bit hold, input bit bw, input bit bd);
    int sx, sy, t;
    logic [16:0] u;
    logic [15:0] wr, sv, fv;
    bit ov, cy;
    @(negedge clk);
    op_valid = v; op_code = 3'(op); dst_sel = dst; opnd_x = x; opnd_y = y;
    mode_sat_en = sat; mode_ovf_hold = hold; bus_ovf_we = bw; bus_ovf_data = bd;
    sx = int'($signed(x)); sy = int'($signed(y));
    t = 0; cy = 0; ov = 0;
    case (op)
      0: begin t = sx + sy; u = {1'b0, x} + {1'b0, y}; cy = u[16]; end
      1: begin t = sx - sy; cy = (x >= y); end
      default: t = 0;
    endcase
    case (op)
      0, 1: wr = t[15:0];
      2: wr = y;
      3: wr = x & y;
      4: wr = x | y;
      5: wr = x ^ y;
      6: wr = x;
      default: wr = ~x;
    endcase
    if (op <= 1) ov = (t > 32767) || (t < -32768);
    sv = ov ? ((t > 0) ? 16'h7FFF : 16'h8000) : wr;
    fv = sat ? sv : wr;
    if (v) begin
      if (!dst) e_res = sat ? sv : wr;
      else      e_fbk = wr;
      e_z = (fv == 16'h0000);
      e_n = fv[15];
      e_c = cy;
    end
    if (bw)     e_v = bd;
    else if (v) e_v = hold ? (e_v | ov) : ov;
    @(negedge clk);
    op_valid = 0; bus_ovf_we = 0;
    compare_all(tag);
  endtask

  task automatic t_reset;
    compare_all("R1");
  endtask

  task automatic t_basic_ops;
    apply("R2", 1, 0, 0, 16'h1234, 16'h1111, 0, 0, 0, 0);
    apply("R7", 1, 0, 0, 16'hFFFF, 16'h0001, 0, 0, 0, 0);
    apply("R7", 1, 1, 0, 16'h0005, 16'h0007, 0, 0, 0, 0);
    apply("R7", 1, 1, 0, 16'h0007, 16'h0005, 0, 0, 0, 0);
    apply("R2", 1, 2, 0, 16'hAAAA, 16'h8421, 0, 0, 0, 0);
    apply("R2", 1, 3, 0, 16'hF0F0, 16'h3C3C, 0, 0, 0, 0);
    apply("R2", 1, 4, 0, 16'hF0F0, 16'h0F0E, 0, 0, 0, 0);
    apply("R2", 1, 5, 0, 16'h5555, 16'h5555, 0, 0, 0, 0);
    apply("R2", 1, 6, 0, 16'h8001, 16'h1111, 0, 0, 0, 0);
    apply("R2", 1, 7, 0, 16'h00FF, 16'h0000, 0, 0, 0, 0);
  endtask

  task automatic t_dest;
    apply("R3", 1, 0, 1, 16'h0100, 16'h0023, 0, 0, 0, 0);
    apply("R3", 1, 2, 0, 16'h0000, 16'h4242, 0, 0, 0, 0);
  endtask

  task automatic t_sat_res;
    apply("R4", 1, 0, 0, 16'h7000, 16'h7000, 1, 0, 0, 0);
    apply("R4", 1, 0, 0, 16'h8000, 16'hFFFF, 1, 0, 0, 0);
    apply("R4", 1, 1, 0, 16'h8000, 16'h0001, 1, 0, 0, 0);
    apply("R4", 1, 1, 0, 16'h7FFF, 16'hFFFF, 1, 0, 0, 0);
    apply("R4", 1, 0, 0, 16'h0003, 16'h0004, 1, 0, 0, 0);
  endtask

  task automatic t_sat_fbk;
    apply("R5", 1, 0, 1, 16'h7000, 16'h7000, 1, 0, 0, 0);
    apply("R6", 1, 0, 1, 16'h8000, 16'h8000, 1, 0, 0, 0);
    apply("R6", 1, 0, 1, 16'h8000, 16'h8000, 0, 0, 0, 0);
  endtask

  task automatic t_no_hold;
    apply("R8", 1, 0, 0, 16'h4000, 16'h4000, 0, 0, 0, 0);
    apply("R8", 1, 0, 0, 16'h0001, 16'h0001, 0, 0, 0, 0);
  endtask

  task automatic t_hold;
    apply("R9", 1, 1, 0, 16'h8000, 16'h0001, 0, 1, 0, 0);
    apply("R9", 1, 0, 0, 16'h0002, 16'h0002, 0, 1, 0, 0);
    apply("R9", 1, 3, 1, 16'h0F0F, 16'hFFFF, 0, 1, 0, 0);
    apply("R10", 0, 0, 0, 16'h0000, 16'h0000, 0, 1, 1, 0);
    apply("R10", 1, 0, 0, 16'h0010, 16'h0001, 0, 1, 0, 0);
    apply("R9", 1, 0, 0, 16'h7FFF, 16'h0001, 0, 1, 0, 0);
    apply("R10", 1, 0, 0, 16'h7FFF, 16'h7FFF, 0, 1, 1, 0);
    apply("R10", 1, 0, 0, 16'h0001, 16'h0001, 0, 0, 1, 1);
  endtask

  task automatic t_idle;
    apply("R11", 0, 0, 0, 16'h7FFF, 16'h7FFF, 1, 0, 0, 0);
    apply("R11", 0, 1, 1, 16'h1234, 16'hFFFF, 0, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_ops();
    t_dest();
    t_sat_res();
    t_sat_fbk();
    t_no_hold();
    t_hold();
    t_idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule